// File: doc/BRIEF.md
# Global Interrupt-Channel Access Port

This block sits between a host address/data bus and a set of serial channels. It lets an interrupt service routine reach the channel that currently owns the interrupt without decoding the channel number itself. A captured current-interrupt byte comes in from the interrupt arbiter. It holds a byte count, a source type and a channel number. Four pseudo-registers steer through that byte: a global receive-data read, a global transmit-data write, a byte-count read and a channel-number read.

The block also builds the byte placed on the read bus during an interrupt-acknowledge cycle. An 8-bit write-only vector register supplies the constant bits. A 2-bit mode field in an interrupt-control register decides how many low bits of that vector are replaced by the captured type and channel codes.

The receive and transmit FIFOs sit outside the block. The block only issues one-clock pop and push strobes and takes the head byte of each receive FIFO.

Top module: `gia_access_port`

## Requirements
- R1: The captured interrupt byte has this layout: count in bits 7:5, type in bits 4:2, channel in bits 1:0. A receive type is one whose type bits 1:0 are 11 (codes 011 and 111). A host read at 0x2B under a receive type returns the head byte of the named channel and asserts that channel's pop strobe only.
- R2: A host read at 0x2B under any type that is not a receive type returns 0xFF and asserts no pop strobe.
- R3: A transmit type is one whose type bits 1:0 are 10. A host write at 0x2B under a transmit type asserts the named channel's push strobe, with the write data on the transmit data output. Under any other type the write asserts no push strobe.
- R4: A host read at 0x2A returns the captured count in bits 2:0 and zero in bits 7:3.
- R5: A host read at 0x29 returns the captured channel number in bits 1:0 and zero above. A host read at 0x28 returns the whole captured byte.
- R6: A host write at 0x29 loads the 8-bit vector register. A later read at 0x29 still returns the channel number, not the vector.
- R7: The interrupt-control register at 0x2C can be read and written as 8 bits and resets to zero. Its bits 1:0 are the vector mode.
- R8: While the acknowledge input is high, read data carries the vector. In mode 00 it is the vector register. In mode 01 it is the vector's bits 7:2 with the channel in bits 1:0. In mode 10 it is the vector's bits 7:5, then the type in bits 4:2, then the channel in bits 1:0.
- R9: In vector mode 11 the acknowledge read data is 0xFF.
- R10: While the acknowledge input is high, no pop or push strobe is asserted, whatever the read and write strobes do.
- R11: Each host access yields at most one pop or push strobe, lasting one clock. This holds even when the bus strobe is held for several clocks.
- R12: Read data is zero when neither read nor acknowledge is active, and for reads of unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Host address |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe, level |
| bus_wr | input | 1 | Host write strobe, level |
| bus_rdata | output | 8 | Host read data, combinational |
| iack | input | 1 | Interrupt-acknowledge cycle active |
| cir_i | input | 8 | Captured current-interrupt byte |
| rx_data_i | input | NUM_CH*8 | Head byte of each receive FIFO |
| rx_pop | output | NUM_CH | Receive FIFO pop strobes |
| tx_push | output | NUM_CH | Transmit FIFO push strobes |
| tx_data | output | 8 | Byte to push |

## Verification
The hardest situation to reach is a global data access that overlaps an acknowledge cycle. On a real bus the host does not issue this. Here it is the only way to show that the acknowledge path suppresses FIFO side effects. The bench sweeps all 32 type/channel codes under each vector mode and four vector values. In every case it raises the acknowledge together with a read or write at 0x2B, then compares the pop and push tallies before and after. A second sweep covers all 256 captured bytes with ordinary accesses. Held-strobe accesses show that one access yields exactly one FIFO strobe.

// File: rtl/gia_pkg.sv
package gia_pkg;

    localparam int BYTE_W = 8;

    localparam logic [7:0] A_CUR  = 8'h28;
    localparam logic [7:0] A_CHAN = 8'h29;
    localparam logic [7:0] A_CNT  = 8'h2A;
    localparam logic [7:0] A_FIFO = 8'h2B;
    localparam logic [7:0] A_CTRL = 8'h2C;

    typedef struct packed {
        logic [2:0] count;
        logic [2:0] kind;
        logic [1:0] chan;
    } cur_irq_t;

    typedef enum logic [1:0] {
        VEC_FULL      = 2'b00,
        VEC_CHAN      = 2'b01,
        VEC_KIND_CHAN = 2'b10,
        VEC_NONE      = 2'b11
    } vec_mode_e;

    function automatic logic kind_is_rx(input logic [2:0] k);
        return k[1:0] == 2'b11;
    endfunction

    function automatic logic kind_is_tx(input logic [2:0] k);
        return k[1:0] == 2'b10;
    endfunction

    function automatic logic [BYTE_W-1:0] make_vector(input vec_mode_e mode,
                                                      input logic [BYTE_W-1:0] base,
                                                      input cur_irq_t cur);
        logic [BYTE_W-1:0] v;
        unique case (mode)
            VEC_FULL:      v = base;
            VEC_CHAN:      v = {base[7:2], cur.chan};
            VEC_KIND_CHAN: v = {base[7:5], cur.kind, cur.chan};
            default:       v = '1;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gia_strobe_edge.sv
module gia_strobe_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] level,
    output logic [N-1:0] start
);
    logic [N-1:0] level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= '0;
        else     level_q <= level;
    end

    assign start = level & ~level_q;
endmodule

// File: rtl/gia_ctrl_regs.sv
module gia_ctrl_regs
    import gia_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_start,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] vec_base,
    output logic [BYTE_W-1:0] ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vec_base <= '0;
            ctrl     <= '0;
        end else if (wr_start) begin
            if (addr == ADDR_W'(A_CHAN)) vec_base <= wdata;
            if (addr == ADDR_W'(A_CTRL)) ctrl     <= wdata;
        end
    end
endmodule

// File: rtl/gia_route.sv
module gia_route
    import gia_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  cur_irq_t                 cur,
    input  logic                     rd_start,
    input  logic                     wr_start,
    input  logic                     fifo_hit,
    input  logic                     iack,
    input  logic [NUM_CH*BYTE_W-1:0] rx_data_i,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [NUM_CH-1:0]        rx_pop,
    output logic [NUM_CH-1:0]        tx_push,
    output logic [BYTE_W-1:0]        tx_data,
    output logic [BYTE_W-1:0]        rx_byte
);
    logic [NUM_CH-1:0] sel;
    logic rx_ok, tx_ok, pop_go, push_go;

    assign rx_ok   = kind_is_rx(cur.kind);
    assign tx_ok   = kind_is_tx(cur.kind);
    assign pop_go  = rd_start & fifo_hit & ~iack & rx_ok;
    assign push_go = wr_start & fifo_hit & ~iack & tx_ok;
    assign tx_data = wdata;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        assign sel[ch]     = (cur.chan == 2'(ch));
        assign rx_pop[ch]  = sel[ch] & pop_go;
        assign tx_push[ch] = sel[ch] & push_go;
    end

    always_comb begin
        rx_byte = '1;
        if (rx_ok) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (sel[ch]) rx_byte = rx_data_i[ch*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/gia_access_port.sv
module gia_access_port
    import gia_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [7:0]               bus_wdata,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    output logic [7:0]               bus_rdata,
    input  logic                     iack,
    input  logic [7:0]               cir_i,
    input  logic [NUM_CH*8-1:0]      rx_data_i,
    output logic [NUM_CH-1:0]        rx_pop,
    output logic [NUM_CH-1:0]        tx_push,
    output logic [7:0]               tx_data
);
    cur_irq_t          cur;
    logic [1:0]        starts;
    logic              rd_start, wr_start, fifo_hit;
    logic [BYTE_W-1:0] vec_base, icr_q, rx_byte, vec_out;

    assign cur      = cur_irq_t'(cir_i);
    assign fifo_hit = (bus_addr == ADDR_W'(A_FIFO));

    gia_strobe_edge #(.N(2)) edge_i (
        .clk   (clk),
        .rst   (rst),
        .level ({bus_wr, bus_rd}),
        .start (starts)
    );
    assign rd_start = starts[0];
    assign wr_start = starts[1];

    gia_ctrl_regs #(.ADDR_W(ADDR_W)) regs_i (
        .clk      (clk),
        .rst      (rst),
        .wr_start (wr_start),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .vec_base (vec_base),
        .ctrl     (icr_q)
    );

    gia_route #(.NUM_CH(NUM_CH)) route_i (
        .cur       (cur),
        .rd_start  (rd_start),
        .wr_start  (wr_start),
        .fifo_hit  (fifo_hit),
        .iack      (iack),
        .rx_data_i (rx_data_i),
        .wdata     (bus_wdata),
        .rx_pop    (rx_pop),
        .tx_push   (tx_push),
        .tx_data   (tx_data),
        .rx_byte   (rx_byte)
    );

    assign vec_out = make_vector(vec_mode_e'(icr_q[1:0]), vec_base, cur);

    always_comb begin
        bus_rdata = '0;
        if (iack) begin
            bus_rdata = vec_out;
        end else if (bus_rd) begin
            unique case (bus_addr)
                ADDR_W'(A_CUR):  bus_rdata = cir_i;
                ADDR_W'(A_CHAN): bus_rdata = {6'b0, cur.chan};
                ADDR_W'(A_CNT):  bus_rdata = {5'b0, cur.count};
                ADDR_W'(A_FIFO): bus_rdata = rx_byte;
                ADDR_W'(A_CTRL): bus_rdata = icr_q;
                default:         bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/gia_access_port_chk.sv
module gia_access_port_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic [7:0]        bus_rdata,
    input logic              iack,
    input logic [7:0]        cir_i,
    input logic [7:0]        icr_q,
    input logic [NUM_CH-1:0] rx_pop,
    input logic [NUM_CH-1:0] tx_push
);
    p_pop_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rx_pop));

    p_pop_rx_only_r2: assert property (@(posedge clk) disable iff (rst)
        (|rx_pop) |-> (cir_i[3:2] == 2'b11));

    p_push_tx_only_r3: assert property (@(posedge clk) disable iff (rst)
        (|tx_push) |-> (cir_i[3:2] == 2'b10));

    p_count_read_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !iack && bus_addr == ADDR_W'(8'h2A)) |-> (bus_rdata == {5'b0, cir_i[7:5]}));

    p_vec_none_r9: assert property (@(posedge clk) disable iff (rst)
        (iack && icr_q[1:0] == 2'b11) |-> (bus_rdata == 8'hFF));

    p_iack_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        iack |-> (rx_pop == '0 && tx_push == '0));

    p_pop_single_r11: assert property (@(posedge clk) disable iff (rst)
        (|rx_pop) |=> (rx_pop == '0));

    p_push_single_r11: assert property (@(posedge clk) disable iff (rst)
        (|tx_push) |=> (tx_push == '0));
endmodule

bind gia_access_port gia_access_port_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .iack      (iack),
    .cir_i     (cir_i),
    .icr_q     (icr_q),
    .rx_pop    (rx_pop),
    .tx_push   (tx_push)
);

// File: tb/gia_access_port_tb_top.sv
`timescale 1ns/1ps
module gia_access_port_tb_top;
    localparam int NCH = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [7:0]      bus_addr = '0, bus_wdata = '0, cir_i = '0;
    logic            bus_rd = 1'b0, bus_wr = 1'b0, iack = 1'b0;
    logic [7:0]      bus_rdata, tx_data;
    logic [NCH*8-1:0] rx_data_i;
    logic [NCH-1:0]  rx_pop, tx_push;

    int checks = 0, errors = 0;
    int pops [NCH];
    int pushes [NCH];
    int exp_pops [NCH];
    int exp_pushes [NCH];
    logic [7:0] last_push = '0;

    always #10 clk = ~clk;

    gia_access_port #(.NUM_CH(NCH), .ADDR_W(8)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata), .iack(iack),
        .cir_i(cir_i), .rx_data_i(rx_data_i), .rx_pop(rx_pop),
        .tx_push(tx_push), .tx_data(tx_data)
    );

    function automatic logic [7:0] head_byte(input int ch);
        return 8'h3C ^ 8'(ch * 8'h55);
    endfunction

    for (genvar g = 0; g < NCH; g++) begin : g_rx
        assign rx_data_i[g*8 +: 8] = head_byte(g);
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            pops[i] = 0; pushes[i] = 0; exp_pops[i] = 0; exp_pushes[i] = 0;
        end
    end

    always @(negedge clk) begin
        for (int i = 0; i < NCH; i++) begin
            if (rx_pop[i]) pops[i]++;
            if (tx_push[i]) begin pushes[i]++; last_push = tx_data; end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_tallies(input string req);
        for (int i = 0; i < NCH; i++) begin
            chk({req, " pop tally"}, pops[i], exp_pops[i]);
            chk({req, " push tally"}, pushes[i], exp_pushes[i]);
        end
    endtask

    task automatic access(input bit is_wr, input logic [7:0] a, input logic [7:0] d,
                          input int hold, input bit ack, output logic [7:0] seen);
        @(posedge clk); #2;
        bus_addr = a; bus_wdata = d; bus_rd = !is_wr; bus_wr = is_wr; iack = ack;
        #5 seen = bus_rdata;
        repeat (hold) @(posedge clk);
        #2 bus_rd = 1'b0; bus_wr = 1'b0; iack = 1'b0;
        @(posedge clk); #2;
    endtask

    logic [7:0] got;

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(posedge clk); #5;
        chk("R12 idle read data", bus_rdata, 8'h00);
        access(0, 8'h2C, 0, 1, 0, got);
        chk("R7 control reset", got, 8'h00);
        access(0, 8'h00, 0, 1, 1, got);
        chk("R8 reset vector", got, 8'h00);

        for (int c = 0; c < 256; c++) begin
            logic [7:0] cv;
            logic [1:0] ch;
            logic [7:0] exp_rx;
            bit rx_kind, tx_kind;
            cv = 8'(c); ch = cv[1:0];
            rx_kind = (cv[3:2] == 2'b11);
            tx_kind = (cv[3:2] == 2'b10);
            cir_i = cv;
            access(0, 8'h2B, 0, 1, 0, got);
            exp_rx = rx_kind ? head_byte(int'(ch)) : 8'hFF;
            if (rx_kind) begin
                exp_pops[ch]++;
                chk("R1 global receive byte", got, exp_rx);
                chk_tallies("R1");
            end else begin
                chk("R2 refused receive byte", got, exp_rx);
                chk_tallies("R2");
            end
            access(1, 8'h2B, cv ^ 8'h5A, 1, 0, got);
            if (tx_kind) begin
                exp_pushes[ch]++;
                chk("R3 pushed byte", last_push, cv ^ 8'h5A);
            end
            chk_tallies("R3");
            access(0, 8'h2A, 0, 1, 0, got);
            chk("R4 count read", got, {5'b0, cv[7:5]});
            access(0, 8'h29, 0, 1, 0, got);
            chk("R5 channel read", got, {6'b0, cv[1:0]});
            access(0, 8'h28, 0, 1, 0, got);
            chk("R5 full byte read", got, cv);
            #5 chk("R12 idle after access", bus_rdata, 8'h00);
        end

        access(0, 8'h2D, 0, 1, 0, got);
        chk("R12 unmapped read", got, 8'h00);
        access(0, 8'h00, 0, 1, 0, got);
        chk("R12 unmapped read low", got, 8'h00);

        cir_i = 8'b101_011_10;
        access(0, 8'h2B, 0, 4, 0, got);
        exp_pops[2]++;
        chk_tallies("R11 held read");
        cir_i = 8'b010_110_01;
        access(1, 8'h2B, 8'hC3, 4, 0, got);
        exp_pushes[1]++;
        chk_tallies("R11 held write");
        chk("R11 held write data", last_push, 8'hC3);

        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 4; b++) begin
                logic [7:0] base, ctl;
                base = (b == 0) ? 8'h00 : (b == 1) ? 8'hFF : (b == 2) ? 8'hA5 : 8'h5A;
                ctl  = 8'((b * 8'h44) | m);
                access(1, 8'h2C, ctl, 1, 0, got);
                access(0, 8'h2C, 0, 1, 0, got);
                chk("R7 control readback", got, ctl);
                access(1, 8'h29, base, 1, 0, got);
                cir_i = 8'b110_000_11;
                access(0, 8'h29, 0, 1, 0, got);
                chk("R6 vector is write-only", got, 8'h03);
                for (int k = 0; k < 32; k++) begin
                    logic [7:0] cv, ev;
                    cv = 8'(k) | 8'hE0;
                    cir_i = cv;
                    case (m)
                        0: ev = base;
                        1: ev = {base[7:2], cv[1:0]};
                        2: ev = {base[7:5], cv[4:2], cv[1:0]};
                        default: ev = 8'hFF;
                    endcase
                    access(k[0], 8'h2B, 8'h77, 1, 1, got);
                    if (m == 3) chk("R9 vector disabled", got, ev);
                    else        chk("R8 vector build", got, ev);
                    chk_tallies("R10 no strobes in acknowledge");
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule